// File: doc/BRIEF.md
# Integer Multiply and Multiply-Add Unit

This unit is the multiply engine of an integer execution pipeline. One start pulse captures an operation code and up to three 64-bit operands, plus a 16-bit immediate. The unit forms the full 128-bit product of two operands. It can add a third operand to that product. It then returns either the low or the high 64 bits of the result. Variants cover signed and unsigned operands, word-sized (32-bit) operands, an immediate multiplier and multiply-add.

Every operand is first widened to 128 bits, by sign extension or zero extension, so a single multiply-accumulate path serves all operation codes. The result, an overflow flag and a three-bit sign classification come out together with a one-cycle done pulse. A start that arrives while an operation is still in flight is dropped.

Top module: `imul_madd_unit`

## Requirements
- R1: Op code 0 returns the low 64 bits of the signed product a×b. The overflow flag is 1 unless product bits 127 down to 63 are all zero or all one.
- R2: Op code 1 returns the upper 64 bits of the signed 128-bit product a×b. Op code 2 returns the upper 64 bits of the unsigned product.
- R3: Op code 3 multiplies the signed low 32 bits of a and b into a 64-bit result. The overflow flag is 1 unless bits 63 down to 31 of that product are all zero or all one.
- R4: Op codes 4 (signed) and 5 (unsigned) place bits 63 down to 32 of the 32×32 word product into result bits 31 down to 0. Result bits 63 down to 32 are driven to zero.
- R5: Op code 6 multiplies a by the sign-extended 16-bit immediate and returns the low 64 bits.
- R6: Op code 7 returns the upper 64 bits of signed a×b plus sign-extended c. Op code 8 returns the upper 64 bits of unsigned a×b plus zero-extended c. Op code 9 returns the low 64 bits of a×b+c.
- R7: The overflow flag is 0 for every op code except 0 and 3.
- R8: The condition output has exactly one bit set. Bit 2 means the result is negative as a signed value, bit 1 means positive, bit 0 means zero.
- R9: A start seen with busy low is accepted on that clock edge. Busy is then high for the next two cycles. Done is high for exactly one cycle, starting after the second rising edge that follows the accepting edge, and outputs are valid while done is high. A start in the cycle where done is high is accepted.
- R10: A start that arrives while busy is high is ignored. It produces no done pulse and does not alter the result of the operation in flight.
- R11: Reset clears done, busy, the result, the overflow flag and the condition output. Between done pulses, the result, overflow and condition outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new operation |
| op_i | input | 4 | Operation code (0 to 9) |
| a_i | input | 64 | First multiplicand |
| b_i | input | 64 | Second multiplicand |
| c_i | input | 64 | Addend for multiply-add |
| imm_i | input | 16 | Signed immediate multiplier for op 6 |
| busy_o | output | 1 | An operation is in flight; starts are ignored |
| done_o | output | 1 | One-cycle pulse: outputs are valid |
| result_o | output | 64 | Selected 64-bit result |
| ovf_o | output | 1 | Overflow of low-half results |
| cond_o | output | 3 | Sign class of result: {negative, positive, zero} |

## Verification
Two events share a cycle in this unit: an operation's done pulse, and the acceptance of the next start. The driver issues each new request as soon as busy falls, so every back-to-back pair raises start in the very cycle where done is high. The scoreboard then requires both operations to complete in the order they were issued, with correct values. A second collision holds start high, with different operands, through the two busy cycles. The bench expects exactly one completion carrying the first operation's values, and the monitor treats any extra done pulse as a failure.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam int unsigned XLEN   = 64;
    localparam int unsigned HALF   = XLEN / 2;
    localparam int unsigned WIDE   = 2 * XLEN;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned COND_W = 3;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [HALF-1:0]   half_t;
    typedef logic [WIDE-1:0]   wide_t;
    typedef logic [IMM_W-1:0]  imm_t;
    typedef logic [COND_W-1:0] cond_t;

    typedef enum logic [OP_W-1:0] {
        OP_LO_D    = 4'd0,
        OP_HI_DS   = 4'd1,
        OP_HI_DU   = 4'd2,
        OP_LO_W    = 4'd3,
        OP_HI_WS   = 4'd4,
        OP_HI_WU   = 4'd5,
        OP_LO_IMM  = 4'd6,
        OP_MADD_HS = 4'd7,
        OP_MADD_HU = 4'd8,
        OP_MADD_L  = 4'd9
    } op_e;

    // Operands after widening, waiting for the multiply stage
    typedef struct packed {
        logic  valid;
        op_e   op;
        wide_t a_x;
        wide_t b_x;
        wide_t c_x;
    } ext_ops_t;

    // Full-width product plus addend
    typedef struct packed {
        logic  valid;
        op_e   op;
        wide_t sum;
    } prod_t;

    function automatic wide_t sx_word(input word_t v);
        return {{XLEN{v[XLEN-1]}}, v};
    endfunction

    function automatic wide_t zx_word(input word_t v);
        return {{XLEN{1'b0}}, v};
    endfunction

    function automatic wide_t sx_half(input half_t v);
        return {{(WIDE-HALF){v[HALF-1]}}, v};
    endfunction

    function automatic wide_t zx_half(input half_t v);
        return {{(WIDE-HALF){1'b0}}, v};
    endfunction

    function automatic wide_t sx_imm(input imm_t v);
        return {{(WIDE-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    // {negative, positive, zero}
    function automatic cond_t classify(input word_t r);
        if (r[XLEN-1])
            return 3'b100;
        else if (r == '0)
            return 3'b001;
        else
            return 3'b010;
    endfunction

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep
    import imul_pkg::*;
(
    input  op_e   op,
    input  word_t a,
    input  word_t b,
    input  word_t c,
    input  imm_t  imm,
    output wide_t a_x,
    output wide_t b_x,
    output wide_t c_x
);

    always_comb begin
        a_x = sx_word(a);
        b_x = sx_word(b);
        c_x = '0;
        unique case (op)
            OP_HI_DU: begin
                a_x = zx_word(a);
                b_x = zx_word(b);
            end
            OP_LO_W, OP_HI_WS: begin
                a_x = sx_half(a[HALF-1:0]);
                b_x = sx_half(b[HALF-1:0]);
            end
            OP_HI_WU: begin
                a_x = zx_half(a[HALF-1:0]);
                b_x = zx_half(b[HALF-1:0]);
            end
            OP_LO_IMM: begin
                b_x = sx_imm(imm);
            end
            OP_MADD_HS, OP_MADD_L: begin
                c_x = sx_word(c);
            end
            OP_MADD_HU: begin
                a_x = zx_word(a);
                b_x = zx_word(b);
                c_x = zx_word(c);
            end
            default: begin
                a_x = sx_word(a);
                b_x = sx_word(b);
            end
        endcase
    end

endmodule

// File: rtl/imul_product_stage.sv
module imul_product_stage
    import imul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ext_ops_t ops,
    output prod_t    prod
);

    // Because operands are pre-widened to WIDE bits, the low WIDE bits of
    // this product are exact for both signed and unsigned interpretations.
    wide_t mac;
    assign mac = (ops.a_x * ops.b_x) + ops.c_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else begin
            prod.valid <= ops.valid;
            if (ops.valid) begin
                prod.op  <= ops.op;
                prod.sum <= mac;
            end
        end
    end

endmodule

// File: rtl/imul_result_sel.sv
module imul_result_sel
    import imul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  prod_t  prod,
    output logic   done,
    output word_t  result,
    output logic   ovf,
    output cond_t  cond
);

    word_t sel_res;
    logic  sel_ovf;
    op_e   op_q;

    wire [XLEN:0] top_d = prod.sum[WIDE-1:XLEN-1];
    wire [HALF:0] top_w = prod.sum[XLEN-1:HALF-1];

    always_comb begin
        sel_res = prod.sum[XLEN-1:0];
        sel_ovf = 1'b0;
        unique case (prod.op)
            OP_LO_D: begin
                sel_ovf = !((&top_d) || !(|top_d));
            end
            OP_LO_W: begin
                sel_ovf = !((&top_w) || !(|top_w));
            end
            OP_HI_DS, OP_HI_DU, OP_MADD_HS, OP_MADD_HU: begin
                sel_res = prod.sum[WIDE-1:XLEN];
            end
            OP_HI_WS, OP_HI_WU: begin
                sel_res = {{HALF{1'b0}}, prod.sum[XLEN-1:HALF]};
            end
            default: begin
                sel_res = prod.sum[XLEN-1:0];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
            ovf    <= 1'b0;
            cond   <= '0;
            op_q   <= OP_LO_D;
        end else begin
            done <= prod.valid;
            if (prod.valid) begin
                result <= sel_res;
                ovf    <= sel_ovf;
                cond   <= classify(sel_res);
                op_q   <= prod.op;
            end
        end
    end

    // R7: overflow may only be reported by the two low-half forms
    a_r7_ovf_only_low: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> (op_q == OP_LO_D || op_q == OP_LO_W));

    // R8: exactly one sign class is flagged on every completion
    a_r8_cond_onehot: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(cond) == 1));

    // R4: the upper half of word-high results is zero
    a_r4_word_high_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_HI_WS || op_q == OP_HI_WU)) |-> (result[XLEN-1:HALF] == '0));

    // R11: outputs hold between completions
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(ovf) && $stable(cond)));

endmodule

// File: rtl/imul_madd_unit.sv
module imul_madd_unit
    import imul_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [XLEN-1:0]     a_i,
    input  logic [XLEN-1:0]     b_i,
    input  logic [XLEN-1:0]     c_i,
    input  logic [IMM_W-1:0]    imm_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [XLEN-1:0]     result_o,
    output logic                ovf_o,
    output logic [COND_W-1:0]   cond_o
);

    ext_ops_t s1;
    prod_t    s2;
    wide_t    ax_n, bx_n, cx_n;
    logic     accept;

    assign busy_o = s1.valid | s2.valid;
    assign accept = start_i && !busy_o;

    imul_operand_prep u_prep (
        .op  (op_e'(op_i)),
        .a   (a_i),
        .b   (b_i),
        .c   (c_i),
        .imm (imm_i),
        .a_x (ax_n),
        .b_x (bx_n),
        .c_x (cx_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= accept;
            if (accept) begin
                s1.op  <= op_e'(op_i);
                s1.a_x <= ax_n;
                s1.b_x <= bx_n;
                s1.c_x <= cx_n;
            end
        end
    end

    imul_product_stage u_prod (
        .clk  (clk),
        .rst  (rst),
        .ops  (s1),
        .prod (s2)
    );

    imul_result_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .prod   (s2),
        .done   (done_o),
        .result (result_o),
        .ovf    (ovf_o),
        .cond   (cond_o)
    );

    // R9: an accepted start completes with done on the third following sample
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> ##2 done_o);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: a start while busy does not enter the pipeline
    a_r10_busy_drop: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !s1.valid);

endmodule

// File: tb/imul_madd_unit_test.sv
module imul_madd_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0, b_i = '0, c_i = '0;
    logic [15:0] imm_i = '0;
    logic        busy_o, done_o, ovf_o;
    logic [63:0] result_o;
    logic [2:0]  cond_o;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int dones  = 0;
    int cycles = 0;
    logic [63:0] last_res = '0;

    typedef struct {
        logic [63:0] res;
        logic        ovf;
        logic [2:0]  cond;
        string       tag;
    } exp_t;

    exp_t scb[$];

    always #5 clk = ~clk;

    imul_madd_unit uut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .imm_i(imm_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .ovf_o(ovf_o), .cond_o(cond_o)
    );

    function automatic exp_t model(input int op, input logic [63:0] a, input logic [63:0] b,
                                   input logic [63:0] c, input logic [15:0] imm, input string tag);
        exp_t e;
        logic signed [127:0] sa, sb, sc, sp;
        logic [127:0] up;
        logic signed [63:0] pw;
        logic [63:0] uw;
        sa = $signed(a);
        sb = $signed(b);
        sc = $signed(c);
        sp = sa * sb;
        up = {64'd0, a} * {64'd0, b};
        pw = $signed(a[31:0]) * $signed(b[31:0]);
        uw = a[31:0] * b[31:0];
        e.ovf = 1'b0;
        e.tag = tag;
        case (op)
            0: begin
                e.res = sp[63:0];
                e.ovf = !(sp[127:63] == '0 || sp[127:63] == '1);
            end
            1: e.res = sp[127:64];
            2: e.res = up[127:64];
            3: begin
                e.res = pw;
                e.ovf = !(pw[63:31] == '0 || pw[63:31] == '1);
            end
            4: e.res = {32'd0, pw[63:32]};
            5: e.res = {32'd0, uw[63:32]};
            6: begin
                sp = sa * 128'($signed(imm));
                e.res = sp[63:0];
            end
            7: begin
                sp = sa * sb + sc;
                e.res = sp[127:64];
            end
            8: begin
                up = {64'd0, a} * {64'd0, b} + {64'd0, c};
                e.res = up[127:64];
            end
            default: begin
                sp = sa * sb + sc;
                e.res = sp[63:0];
            end
        endcase
        if ($signed(e.res) < 0)      e.cond = 3'b100;
        else if (e.res == 64'd0)     e.cond = 3'b001;
        else                         e.cond = 3'b010;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: waits at a falling edge until the unit is free, then issues
    task automatic issue(input int op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input logic [15:0] imm, input string tag);
        while (busy_o) @(negedge clk);
        scb.push_back(model(op, a, b, c, imm, tag));
        pushed++;
        start_i = 1'b1;
        op_i = 4'(op);
        a_i = a; b_i = b; c_i = c; imm_i = imm;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (busy_o || scb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares on every completion
    always @(negedge clk) begin
        if (!rst && done_o) begin
            dones++;
            if (scb.size() == 0) begin
                check(1'b0, "R10", "done without pending request", {63'd0, done_o}, 64'd0);
            end else begin
                exp_t e;
                e = scb.pop_front();
                check(result_o == e.res, e.tag, "result", result_o, e.res);
                check(ovf_o == e.ovf, e.tag, "ovf", {63'd0, ovf_o}, {63'd0, e.ovf});
                check(cond_o == e.cond, "R8", "cond", {61'd0, cond_o}, {61'd0, e.cond});
                last_res = result_o;
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            finish_run();
        end
    end

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(done_o == 1'b0 && busy_o == 1'b0, "R11", "reset done/busy",
              {62'd0, done_o, busy_o}, 64'd0);
        check(result_o == 64'd0 && ovf_o == 1'b0 && cond_o == 3'd0, "R11", "reset outputs",
              result_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R9: exact handshake timing
        start_i = 1'b1; op_i = 4'd0; a_i = 64'd6; b_i = 64'd7; c_i = '0; imm_i = '0;
        scb.push_back(model(0, 64'd6, 64'd7, 64'd0, 16'd0, "R9")); pushed++;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R9", "busy cycle 1", {62'd0, busy_o, done_o}, 64'd2);
        @(negedge clk);
        check(busy_o && !done_o, "R9", "busy cycle 2", {62'd0, busy_o, done_o}, 64'd2);
        @(negedge clk);
        check(!busy_o && done_o, "R9", "done cycle", {62'd0, busy_o, done_o}, 64'd1);
        @(negedge clk);
        check(!done_o, "R9", "done one cycle", {63'd0, done_o}, 64'd0);

        // R1: low doubleword, with and without overflow
        issue(0, 64'd123456789, ONES - 64'd4, 64'd0, 16'd0, "R1");
        issue(0, MIN64, ONES, 64'd0, 16'd0, "R1");
        issue(0, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'd0, 16'd0, "R1");
        issue(0, 64'd0, 64'hDEAD_BEEF, 64'd0, 16'd0, "R1");
        // R2: high doubleword, signed and unsigned
        issue(1, ONES, ONES, 64'd0, 16'd0, "R2");
        issue(2, ONES, ONES, 64'd0, 16'd0, "R2");
        issue(1, MIN64, 64'd3, 64'd0, 16'd0, "R2");
        // R3: low word
        issue(3, 64'hAAAA_AAAA_7FFF_FFFF, 64'd2, 64'd0, 16'd0, "R3");
        issue(3, 64'h1234_5678_FFFF_FFFD, 64'h0000_0000_0000_0005, 64'd0, 16'd0, "R3");
        // R4: high word
        issue(4, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0003, 64'd0, 16'd0, "R4");
        issue(5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_1111_FFFF_FFFF, 64'd0, 16'd0, "R4");
        // R5: immediate
        issue(6, 64'd1000, 64'hFFFF_0000_0000_0000, 64'd0, 16'hFFF6, "R5");
        issue(6, MIN64, 64'd0, 64'd0, 16'h7FFF, "R5");
        // R6: multiply-add
        issue(7, ONES, 64'd1, ONES, 16'd0, "R6");
        issue(8, ONES, 64'd1, ONES, 16'd0, "R6");
        issue(9, 64'd5, 64'd5, ONES - 64'd24, 16'd0, "R6");
        // R7: large products in forms that report no overflow
        issue(1, MIN64, MIN64, 64'd0, 16'd0, "R7");
        issue(9, MIN64, 64'd2, 64'd0, 16'd0, "R7");
        drain();

        // R10: start held through busy with different operands
        scb.push_back(model(0, 64'd11, 64'd13, 64'd0, 16'd0, "R10")); pushed++;
        start_i = 1'b1; op_i = 4'd0; a_i = 64'd11; b_i = 64'd13;
        @(negedge clk);
        op_i = 4'd2; a_i = ONES; b_i = ONES;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        check(dones == pushed, "R10", "completions", 64'(dones), 64'(pushed));
        // R11: hold after completion
        check(result_o == last_res && !done_o, "R11", "hold", result_o, last_res);
        repeat (3) @(negedge clk);
        check(result_o == 64'd143, "R11", "hold later", result_o, 64'd143);

        // Mixed random traffic across all op codes
        for (int i = 0; i < 40; i++) begin
            logic [63:0] ra, rb, rc;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rc = {$urandom, $urandom};
            issue(int'($urandom_range(0, 9)), ra, rb, rc, 16'($urandom), "R6");
        end
        drain();
        check(scb.size() == 0 && dones == pushed, "R9", "all completed",
              64'(dones), 64'(pushed));
        finish_run();
    end

endmodule